// File: doc/BRIEF.md
# Multi-Slope Integrating Converter Sequencer

This block is the digital controller of an integrating analog-to-digital converter whose deintegration uses two slopes. It divides the system clock down to a conversion tick. On each tick it drives the analog switch selects through a fixed sequence: auto-zero, signal integration, a one-tick sign decision, coarse deintegration and fine deintegration. It samples a single comparator and forms a 15-bit magnitude, a sign flag and an overrange flag. Coarse deintegration uses the full reference and counts in a 9-bit up/down counter. Fine deintegration uses a reference 64 times weaker, of opposite direction, and counts down a 6-bit counter that borrows from the coarse one. The final count is therefore 64 × coarse steps − fine steps.

A conversion starts on a strobe while the block is idle (demand mode), or starts again at once after each result while the continuous-mode input is high. The comparator output must reflect the integrator state in front of each tick edge. The coarse and fine switch selects are gated combinationally by the comparator, so that no reference step is applied after a crossing.

Top module: `msadc_seq`

## Requirements
- R1: `tick` is high for exactly one clock cycle out of every CLK_DIV cycles. All phase timing and all switch changes advance only on clock edges where `tick` is high.
- R2: A conversion holds `sw_zero` for AZ_TICKS ticks, then `sw_signal` for INT_TICKS ticks, then one sign-decision tick with no switch on, then the coarse and fine deintegration phases. At most one of the four switch selects is high in any cycle.
- R3: On the sign tick the block records polarity. The result flag `negative` is 1 exactly when `cmp_in` (1 = integrator at or above zero) was low. `ref_dir` = 1 means the reference pushes the integrator upward. During coarse steps `ref_dir` equals the recorded negative polarity, and during fine steps it is the opposite.
- R4: During coarse deintegration, `sw_ref_coarse` is high on each tick while `cmp_in` still shows the recorded polarity. During fine deintegration, `sw_ref_fine` is high on each tick while `cmp_in` shows the opposite side, for at most 64 steps. The magnitude equals 64 × coarse steps − fine steps, which equals the input in the ideal integrator model.
- R5: A zero input gives a magnitude of 0 with `overrange` low.
- R6: If 512 coarse steps pass without a comparator crossing, the conversion ends without a fine phase. `overrange` is then 1 and `magnitude` is all ones (32767).
- R7: `busy` is high from the first coarse tick until completion. `done` is a one-cycle pulse in the cycle where `busy` falls, and `magnitude`, `negative` and `overrange` take their new values in that same cycle.
- R8: With `cont_mode` low, a conversion begins only after a `conv_start` pulse received while idle. A pulse received during a conversion has no effect, and no further conversion follows.
- R9: With `cont_mode` high at completion, auto-zero of the next conversion is already active in the cycle where `done` is high, without any `conv_start`.
- R10: While `rst` is high, every output is 0.
- R11: `magnitude`, `negative` and `overrange` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Start strobe used in demand mode |
| cont_mode | input | 1 | 1 = convert back to back |
| cmp_in | input | 1 | Comparator, 1 = integrator at or above zero |
| tick | output | 1 | Conversion clock enable (clock / CLK_DIV) |
| sw_zero | output | 1 | Auto-zero switch select |
| sw_signal | output | 1 | Signal integration switch select |
| sw_ref_coarse | output | 1 | Full reference switch select |
| sw_ref_fine | output | 1 | Reduced (1/64) reference switch select |
| ref_dir | output | 1 | Reference direction, 1 = push integrator upward |
| busy | output | 1 | High during deintegration |
| done | output | 1 | One-cycle completion pulse |
| magnitude | output | 15 | Result magnitude |
| negative | output | 1 | Result sign, 1 = negative input |
| overrange | output | 1 | Result exceeded full scale |

## Verification
The bound checker watches, on every cycle, that the switch selects stay exclusive, that `tick` never lasts two cycles, that switches move only after a tick, and that `done` is a single pulse at the fall of `busy`. It also checks that results hold between completions and that an overrange always reads full scale. Only the bench scenarios can show that the ideal integrator driven by the selects comes back with the right magnitude and sign for each input. The same holds for the exact phase lengths counted in ticks, the overrange boundary at 32767 versus 32768, zero input, ignored strobes and the back-to-back restart.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

    localparam int COARSE_W   = 9;
    localparam int FINE_W     = 6;
    localparam int MAG_W      = COARSE_W + FINE_W;
    localparam int FINE_LIMIT = 1 << FINE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ZERO,
        PH_SIGNAL,
        PH_SIGN,
        PH_COARSE,
        PH_FINE
    } phase_e;

    typedef struct packed {
        logic zero;
        logic signal;
        logic coarse;
        logic fine;
        logic dir;
    } sw_t;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             neg;
        logic             ovr;
    } result_t;

    // Switch routing for the current phase; deintegration selects are
    // already gated by the comparator decision.
    function automatic sw_t route(phase_e ph, logic c_go, logic f_go, logic pos);
        sw_t s;
        s.zero   = (ph == PH_ZERO);
        s.signal = (ph == PH_SIGNAL);
        s.coarse = c_go;
        s.fine   = f_go;
        if (ph == PH_COARSE)    s.dir = ~pos;
        else if (ph == PH_FINE) s.dir = pos;
        else                    s.dir = 1'b0;
        return s;
    endfunction

    // Chained count to result magnitude; a set carry means no fine step
    // pulled the value back below full scale.
    function automatic logic [MAG_W-1:0] assemble(logic carry,
                                                  logic [COARSE_W-1:0] c,
                                                  logic [FINE_W-1:0] f);
        return carry ? {MAG_W{1'b1}} : {c, f};
    endfunction

endpackage

// File: rtl/msadc_tick_gen.sv
module msadc_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    assign tick = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/msadc_updown.sv
module msadc_updown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         dn,
    output logic [W-1:0] q,
    output logic         wrap
);
    // wrap flags that the next enabled step crosses the end of the range
    assign wrap = dn ? (q == '0) : (q == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (en)    q <= dn ? q - 1'b1 : q + 1'b1;
    end
endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
    import msadc_pkg::*;
#(
    parameter int AZ_TICKS  = 512,
    parameter int INT_TICKS = 256,
    parameter int CLK_DIV   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             cont_mode,
    input  logic             cmp_in,
    output logic             tick,
    output logic             sw_zero,
    output logic             sw_signal,
    output logic             sw_ref_coarse,
    output logic             sw_ref_fine,
    output logic             ref_dir,
    output logic             busy,
    output logic             done,
    output logic [MAG_W-1:0] magnitude,
    output logic             negative,
    output logic             overrange
);
    localparam int PH_MAX = (AZ_TICKS > INT_TICKS) ? AZ_TICKS : INT_TICKS;
    localparam int PCW    = $clog2(PH_MAX + 1);
    localparam int FSW    = FINE_W + 1;

    phase_e              ph, ph_nx;
    logic [PCW-1:0]      pcnt;
    logic                pend, pos, carry;
    logic [FSW-1:0]      fsteps;
    logic [COARSE_W-1:0] cq;
    logic [FINE_W-1:0]   fq;
    logic                c_wrap, f_wrap;
    logic                c_en, c_dn;
    logic                same_side, fine_lim;
    logic                c_go, f_go, c_step, f_step;
    logic                ovr_hit, fine_end, finish, conv_begin;
    sw_t                 sw;
    result_t             res;

    msadc_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    // comparator still on the side recorded at the sign tick
    assign same_side = (cmp_in == pos);
    assign fine_lim  = (fsteps == FSW'(FINE_LIMIT));
    assign c_go      = (ph == PH_COARSE) && same_side && !carry;
    assign f_go      = (ph == PH_FINE) && !same_side && !fine_lim;
    assign c_step    = tick && c_go;
    assign f_step    = tick && f_go;
    assign ovr_hit   = tick && (ph == PH_COARSE) && same_side && carry;
    assign fine_end  = tick && (ph == PH_FINE) && !f_go;
    assign finish    = ovr_hit || fine_end;
    assign conv_begin = (ph_nx == PH_ZERO) && (ph != PH_ZERO);

    // fine counter subtracts one unit per step, borrowing from coarse
    assign c_en = c_step || (f_step && f_wrap);
    assign c_dn = (ph == PH_FINE);

    msadc_updown #(.W(FINE_W)) u_fine (
        .clk  (clk),
        .rst  (rst),
        .clr  (conv_begin),
        .en   (f_step),
        .dn   (1'b1),
        .q    (fq),
        .wrap (f_wrap)
    );

    msadc_updown #(.W(COARSE_W)) u_coarse (
        .clk  (clk),
        .rst  (rst),
        .clr  (conv_begin),
        .en   (c_en),
        .dn   (c_dn),
        .q    (cq),
        .wrap (c_wrap)
    );

    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_IDLE:   if (tick && (pend || cont_mode)) ph_nx = PH_ZERO;
            PH_ZERO:   if (tick && pcnt == PCW'(AZ_TICKS - 1)) ph_nx = PH_SIGNAL;
            PH_SIGNAL: if (tick && pcnt == PCW'(INT_TICKS - 1)) ph_nx = PH_SIGN;
            PH_SIGN:   if (tick) ph_nx = PH_COARSE;
            PH_COARSE: begin
                if (tick && !same_side) ph_nx = PH_FINE;
                else if (ovr_hit)       ph_nx = cont_mode ? PH_ZERO : PH_IDLE;
            end
            PH_FINE:   if (fine_end) ph_nx = cont_mode ? PH_ZERO : PH_IDLE;
            default:   ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            pcnt   <= '0;
            pend   <= 1'b0;
            pos    <= 1'b0;
            carry  <= 1'b0;
            fsteps <= '0;
        end else begin
            ph   <= ph_nx;
            pend <= (ph == PH_IDLE) && (ph_nx != PH_ZERO) && (pend || conv_start);
            if (ph_nx != ph) pcnt <= '0;
            else if (tick && (ph == PH_ZERO || ph == PH_SIGNAL)) pcnt <= pcnt + 1'b1;
            if (tick && ph == PH_SIGN) pos <= cmp_in;
            if (conv_begin) fsteps <= '0;
            else if (f_step) fsteps <= fsteps + 1'b1;
            if (conv_begin) carry <= 1'b0;
            else if (c_step && c_wrap) carry <= 1'b1;
            else if (f_step && f_wrap && c_wrap) carry <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res  <= '0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                res.mag <= ovr_hit ? {MAG_W{1'b1}} : assemble(carry, cq, fq);
                res.neg <= ~pos;
                res.ovr <= ovr_hit;
            end
        end
    end

    assign sw            = route(ph, c_go, f_go, pos);
    assign sw_zero       = sw.zero;
    assign sw_signal     = sw.signal;
    assign sw_ref_coarse = sw.coarse;
    assign sw_ref_fine   = sw.fine;
    assign ref_dir       = sw.dir;
    assign busy          = (ph == PH_COARSE) || (ph == PH_FINE);
    assign magnitude     = res.mag;
    assign negative      = res.neg;
    assign overrange     = res.ovr;

endmodule

// File: rtl/msadc_seq_chk.sv
module msadc_seq_chk
    import msadc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             sw_zero,
    input logic             sw_signal,
    input logic             sw_ref_coarse,
    input logic             sw_ref_fine,
    input logic             busy,
    input logic             done,
    input logic [MAG_W-1:0] magnitude,
    input logic             negative,
    input logic             overrange
);
    p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    p_switch_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sw_zero, sw_signal, sw_ref_coarse, sw_ref_fine}));

    p_phase_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> ($stable(sw_zero) && $stable(sw_signal)));

    p_ovr_full_r6: assert property (@(posedge clk) disable iff (rst)
        overrange |-> (magnitude == {MAG_W{1'b1}}));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(magnitude) && $stable(negative) && $stable(overrange)));
endmodule

bind msadc_seq msadc_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .sw_zero       (sw_zero),
    .sw_signal     (sw_signal),
    .sw_ref_coarse (sw_ref_coarse),
    .sw_ref_fine   (sw_ref_fine),
    .busy          (busy),
    .done          (done),
    .magnitude     (magnitude),
    .negative      (negative),
    .overrange     (overrange)
);

// File: tb/msadc_seq_bench.sv
module msadc_seq_bench;
    import msadc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AZ_T       = 16;
    localparam int INT_T      = 256;
    localparam int DIV        = 4;
    localparam int FULL       = (1 << MAG_W) - 1;
    localparam int OVR_AT     = 1 << MAG_W;
    localparam int F_STEP     = INT_T;
    localparam int C_STEP     = INT_T * (1 << FINE_W);
    localparam int HALF       = INT_T / 2;

    logic clk = 1'b0, rst = 1'b1, conv_start = 1'b0, cont_mode = 1'b0;
    logic cmp_in, tick, sw_zero, sw_signal, sw_ref_coarse, sw_ref_fine, ref_dir;
    logic busy, done, negative, overrange;
    logic [MAG_W-1:0] magnitude;

    int vin = 0;
    int integ = 0;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msadc_seq #(.AZ_TICKS(AZ_T), .INT_TICKS(INT_T), .CLK_DIV(DIV)) u_msadc_seq (
        .clk(clk), .rst(rst), .conv_start(conv_start), .cont_mode(cont_mode),
        .cmp_in(cmp_in), .tick(tick), .sw_zero(sw_zero), .sw_signal(sw_signal),
        .sw_ref_coarse(sw_ref_coarse), .sw_ref_fine(sw_ref_fine), .ref_dir(ref_dir),
        .busy(busy), .done(done), .magnitude(magnitude), .negative(negative),
        .overrange(overrange)
    );

    // Ideal integrator. Auto-zero leaves half a fine step of residue toward
    // the input's sign, so no sample sits exactly on the threshold.
    assign cmp_in = (integ >= 0);
    always @(posedge clk) begin
        if (rst) integ <= 0;
        else if (tick) begin
            if (sw_zero)            integ <= (vin >= 0) ? HALF : -HALF;
            else if (sw_signal)     integ <= integ + vin;
            else if (sw_ref_coarse) integ <= integ + (ref_dir ? C_STEP : -C_STEP);
            else if (sw_ref_fine)   integ <= integ + (ref_dir ? F_STEP : -F_STEP);
        end
    end

    // Port monitor
    int az_ticks = 0, sig_ticks = 0, done_cnt = 0;
    int cap_az = 0, cap_sig = 0, cap_mag = 0;
    logic prev_busy = 1'b0, cap_neg, cap_ovr, cap_busy, cap_prev_busy, cap_zero;
    always @(negedge clk) begin
        if (rst) begin
            az_ticks = 0; sig_ticks = 0; prev_busy = 1'b0;
        end else begin
            if (done) begin
                cap_mag = int'(magnitude); cap_neg = negative; cap_ovr = overrange;
                cap_busy = busy; cap_prev_busy = prev_busy; cap_zero = sw_zero;
                cap_az = az_ticks; cap_sig = sig_ticks;
                az_ticks = 0; sig_ticks = 0;
                done_cnt++;
            end
            if (tick && sw_zero)   az_ticks++;
            if (tick && sw_signal) sig_ticks++;
            prev_busy = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_ovr(input int v);
        return (v >= OVR_AT) || (v <= -OVR_AT);
    endfunction

    function automatic int exp_mag(input int v);
        if (exp_ovr(v)) return FULL;
        return (v < 0) ? -v : v;
    endfunction

    task automatic step_neg();
        @(negedge clk); #1;
    endtask

    task automatic wait_done();
        int n0 = done_cnt;
        for (int i = 0; i < 20000 && done_cnt == n0; i++) step_neg();
        chk(done_cnt != n0, "R7 done timeout", done_cnt, n0 + 1);
    endtask

    task automatic check_result(input int v, input bit cont_next);
        string mreq;
        mreq = exp_ovr(v) ? "R6 magnitude" : (v == 0 ? "R5 magnitude" : "R4 magnitude");
        chk(cap_mag == exp_mag(v), mreq, cap_mag, exp_mag(v));
        chk(cap_ovr == exp_ovr(v), "R6 overrange", int'(cap_ovr), int'(exp_ovr(v)));
        chk(cap_neg == (v < 0), "R3 sign", int'(cap_neg), int'(v < 0));
        chk(cap_az == AZ_T, "R2 auto-zero ticks", cap_az, AZ_T);
        chk(cap_sig == INT_T, "R2 integrate ticks", cap_sig, INT_T);
        chk(!cap_busy && cap_prev_busy, "R7 busy falls with done",
            int'({cap_prev_busy, cap_busy}), 2);
        chk(cap_zero == cont_next, "R9 restart at done", int'(cap_zero), int'(cont_next));
    endtask

    task automatic pulse_start();
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
    endtask

    task automatic run_demand(input int v);
        vin = v;
        pulse_start();
        wait_done();
        check_result(v, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        int t0;
        seed = $urandom(32'd2024);
        repeat (3) step_neg();
        // R10: reset values
        chk({tick, sw_zero, sw_signal, sw_ref_coarse, sw_ref_fine, ref_dir,
             busy, done, negative, overrange} == '0 && magnitude == '0,
            "R10 reset outputs", int'(magnitude), 0);
        rst = 1'b0;

        // R1: tick period and width
        for (int i = 0; i < 8 && !tick; i++) step_neg();
        t0 = 0;
        step_neg();
        chk(!tick, "R1 tick width", int'(tick), 0);
        t0 = 1;
        for (int i = 0; i < 8 && !tick; i++) begin step_neg(); t0++; end
        chk(t0 == DIV, "R1 tick period", t0, DIV);

        // R8: nothing happens without a strobe in demand mode
        repeat (200) step_neg();
        chk(az_ticks == 0 && done_cnt == 0, "R8 idle without strobe", az_ticks, 0);

        // directed corners
        run_demand(0);        // R5
        run_demand(1);        // R4
        run_demand(-1);       // R4 R3
        run_demand(64);       // R4 fine limit case
        run_demand(-64);
        run_demand(63);
        run_demand(32767);    // R4 full scale
        run_demand(-32767);
        run_demand(32768);    // R6
        run_demand(-32768);   // R6
        run_demand(-40000);   // R6

        // R8: strobe during a conversion is ignored
        vin = 5000;
        pulse_start();
        for (int i = 0; i < 20000 && !busy; i++) step_neg();
        pulse_start();
        wait_done();
        check_result(5000, 1'b0);
        repeat ((AZ_T + 8) * DIV * 2) step_neg();
        chk(az_ticks == 0 && !busy, "R8 strobe during conversion ignored", az_ticks, 0);

        // random inputs
        for (int i = 0; i < 10; i++) run_demand(int'($urandom_range(80000, 0)) - 40000);

        // R9: continuous mode
        vin = 1234;
        cont_mode = 1'b1;
        wait_done();
        check_result(1234, 1'b1);
        vin = -777;
        wait_done();
        check_result(-777, 1'b1);
        cont_mode = 1'b0;
        vin = 31000;
        wait_done();
        check_result(31000, 1'b0);
        repeat ((AZ_T + 8) * DIV * 2) step_neg();
        chk(az_ticks == 0, "R9 stops after mode cleared", az_ticks, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule